// File: doc/BRIEF.md
# Scatter-Gather DMA Command and Status Register

This block is the software-facing command word of a scatter-gather DMA engine. Software stages the byte count and buffer address of the following list entry in a pair of "next" registers and sets a start bit. The block moves the staged pair into the "current" registers as soon as the engine has nothing running, or at the moment the running transfer completes. It then reports through the same start bit that the staging registers are free again. This lets software keep exactly one descriptor queued behind the active one without racing the datapath.

The block also tracks the page-interrupt marker of each list entry as the entry moves from staged to current. It latches a page interrupt when a marked page finishes, and keeps a transfer-done flag. It combines both into one interrupt request, gated by per-source enables and by a global interrupt enable input. The datapath, bus mastering and list fetching are outside the block. They appear only as a transfer-complete strobe, a page-complete strobe and an input that carries the marker bit of the entry being staged.

Top module: `sgdma_cmd_reg`

## Requirements
- R1: A command-word write (`cmdWr`) loads bits 15:0 into the staged count, and a `addrWr` write loads the staged address. Both loads take effect only while bit 29 reads 1. `rdSel`=0 returns the command word and `rdSel`=1 returns the staged address.
- R2: Writing 1 to bit 29 while it reads 1 marks the staged pair valid. Bit 29 then reads 0 and bit 22 reads 0 until the handoff, and writes to the staged count or address are ignored in that time.
- R3: A valid staged pair is copied to `curCount`/`curAddr` one clock after it is staged if no transfer is active, or on the clock of `xferDone` if one is. Bit 29 then reads 1 again and `dmaActive` is 1.
- R4: Writing 1 to bit 26 pulses `abortPulse` in the same cycle. It clears the active transfer, the staged pair and bit 30. Bit 26 always reads 0. When written together with bit 29, the abort wins and nothing is staged.
- R5: Bit 30 sets when `xferDone` arrives during an active transfer with nothing staged, and writing 1 to bit 30 clears it. `dmaIrqStat` is bit 30 AND the done-interrupt enable (bit 27).
- R6: Bit 18 sets only while the page-interrupt enable (bit 28) is 1 and `pageDone` arrives for an active current page whose marker is 1. It stays set until bit 28 is written 0.
- R7: Bit 16 holds the `listPgBit` value captured when the start bit is accepted. At handoff it moves to bit 17, and bit 16 returns to 0.
- R8: Bit 23 reads 1 when no transfer is active, and bit 22 reads 1 when nothing is staged. After reset the command word reads 0x20C00000.
- R9: Bits 25 (1 = memory read) and 24 (1 = burst coalescing) are plain read/write bits, driven out on `dirRead` and `burstEn`.
- R10: `irq` is 1 only when `pciIntEn` is 1 and either `dmaIrqStat` or bit 18 is 1.
- R11: Bits 31 and 21:19 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Write strobe for the command word |
| addrWr | input | 1 | Write strobe for the staged address |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read select: 0 command word, 1 staged address |
| rdData | output | 32 | Read data |
| xferDone | input | 1 | Current transfer complete strobe |
| pageDone | input | 1 | Current page complete strobe |
| listPgBit | input | 1 | Page-interrupt marker of the entry being staged |
| pciIntEn | input | 1 | Global interrupt enable |
| curCount | output | 16 | Current transfer byte count |
| curAddr | output | ADDR_W | Current transfer address |
| dmaActive | output | 1 | A transfer is running |
| dirRead | output | 1 | Direction control, 1 = memory read |
| burstEn | output | 1 | Write coalescing enable |
| abortPulse | output | 1 | Abort request to the datapath |
| dmaIrqStat | output | 1 | Gated done interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a second descriptor waiting behind an active one. Staging on an idle engine hands off on the very next clock, so the lock on the staging registers would never be visible. The stimulus therefore stages one entry and lets it hand off. It then stages a second entry while the first still runs, and in that window it tries to overwrite the staged count and address. It also raises a page interrupt from a marked current page and performs an abort together with start.

// File: rtl/sgdma_cmd_pkg.sv
package sgdma_cmd_pkg;
  localparam int DATA_W  = 32;
  localparam int COUNT_W = 16;

  localparam int B_DONE  = 30;
  localparam int B_START = 29;
  localparam int B_ENPG  = 28;
  localparam int B_ENSG  = 27;
  localparam int B_ABORT = 26;
  localparam int B_DIR   = 25;
  localparam int B_BURST = 24;
  localparam int B_IDLE  = 23;
  localparam int B_EMPTY = 22;
  localparam int B_PGFLG = 18;
  localparam int B_CURPG = 17;
  localparam int B_NXTPG = 16;

  typedef struct packed {
    logic loadCount;
    logic loadAddr;
    logic handoff;
  } dpStrobe_t;

  typedef struct packed {
    logic nextValid;
    logic active;
    logic done;
    logic enPg;
    logic enSg;
    logic dirRd;
    logic burst;
    logic pgFlag;
    logic curPg;
    logic nxtPg;
  } ctlState_t;
endpackage

// File: rtl/sgdma_cmd_ctrl.sv
module sgdma_cmd_ctrl
  import sgdma_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              addrWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              xferDone,
  input  logic              pageDone,
  input  logic              listPgBit,
  output dpStrobe_t         strobe,
  output ctlState_t         st,
  output logic              abortReq
);
  logic startReq;
  logic handoff;
  logic lastDone;

  always_comb begin
    abortReq = cmdWr & wrData[B_ABORT];
    startReq = cmdWr & wrData[B_START] & ~st.nextValid & ~abortReq;
    handoff  = st.nextValid & (~st.active | xferDone) & ~abortReq;
    lastDone = xferDone & st.active & ~st.nextValid;
    strobe.loadCount = cmdWr & ~st.nextValid;
    strobe.loadAddr  = addrWr & ~st.nextValid;
    strobe.handoff   = handoff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= '0;
    end else begin
      if (cmdWr) begin
        st.enPg  <= wrData[B_ENPG];
        st.enSg  <= wrData[B_ENSG];
        st.dirRd <= wrData[B_DIR];
        st.burst <= wrData[B_BURST];
      end

      if (abortReq) begin
        st.nextValid <= 1'b0;
        st.active    <= 1'b0;
        st.done      <= 1'b0;
        st.nxtPg     <= 1'b0;
        st.curPg     <= 1'b0;
      end else begin
        if (startReq) begin
          st.nextValid <= 1'b1;
          st.nxtPg     <= listPgBit;
        end else if (handoff) begin
          st.nextValid <= 1'b0;
          st.nxtPg     <= 1'b0;
        end

        if (handoff) begin
          st.active <= 1'b1;
          st.curPg  <= st.nxtPg;
        end else if (xferDone && st.active) begin
          st.active <= 1'b0;
          st.curPg  <= 1'b0;
        end

        if (lastDone) st.done <= 1'b1;
        else if (cmdWr && wrData[B_DONE]) st.done <= 1'b0;
      end

      if (!st.enPg) st.pgFlag <= 1'b0;
      else if (pageDone && st.curPg && st.active) st.pgFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/sgdma_cmd_dpath.sv
module sgdma_cmd_dpath
  import sgdma_cmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  wrData,
  input  dpStrobe_t          strobe,
  output logic [COUNT_W-1:0] nextCount,
  output logic [ADDR_W-1:0]  nextAddr,
  output logic [COUNT_W-1:0] curCount,
  output logic [ADDR_W-1:0]  curAddr
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextCount <= '0;
      nextAddr  <= '0;
      curCount  <= '0;
      curAddr   <= '0;
    end else begin
      if (strobe.loadCount) nextCount <= wrData[COUNT_W-1:0];
      if (strobe.loadAddr)  nextAddr  <= wrData[ADDR_W-1:0];
      if (strobe.handoff) begin
        curCount <= nextCount;
        curAddr  <= nextAddr;
      end
    end
  end
endmodule

// File: rtl/sgdma_cmd_reg.sv
module sgdma_cmd_reg
  import sgdma_cmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWr,
  input  logic               addrWr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdSel,
  output logic [DATA_W-1:0]  rdData,
  input  logic               xferDone,
  input  logic               pageDone,
  input  logic               listPgBit,
  input  logic               pciIntEn,
  output logic [COUNT_W-1:0] curCount,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               dmaActive,
  output logic               dirRead,
  output logic               burstEn,
  output logic               abortPulse,
  output logic               dmaIrqStat,
  output logic               irq
);
  dpStrobe_t          strobe;
  ctlState_t          st;
  logic [COUNT_W-1:0] nextCount;
  logic [ADDR_W-1:0]  nextAddr;
  logic [DATA_W-1:0]  cmdWord;

  sgdma_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .addrWr(addrWr), .wrData(wrData),
    .xferDone(xferDone), .pageDone(pageDone), .listPgBit(listPgBit),
    .strobe(strobe), .st(st), .abortReq(abortPulse)
  );

  sgdma_cmd_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .nextCount(nextCount), .nextAddr(nextAddr),
    .curCount(curCount), .curAddr(curAddr)
  );

  always_comb begin
    cmdWord          = '0;
    cmdWord[COUNT_W-1:0] = nextCount;
    cmdWord[B_DONE]  = st.done;
    cmdWord[B_START] = ~st.nextValid;
    cmdWord[B_ENPG]  = st.enPg;
    cmdWord[B_ENSG]  = st.enSg;
    cmdWord[B_DIR]   = st.dirRd;
    cmdWord[B_BURST] = st.burst;
    cmdWord[B_IDLE]  = ~st.active;
    cmdWord[B_EMPTY] = ~st.nextValid;
    cmdWord[B_PGFLG] = st.pgFlag;
    cmdWord[B_CURPG] = st.curPg;
    cmdWord[B_NXTPG] = st.nxtPg;
    rdData     = rdSel ? DATA_W'(nextAddr) : cmdWord;
    dmaActive  = st.active;
    dirRead    = st.dirRd;
    burstEn    = st.burst;
    dmaIrqStat = st.done & st.enSg;
    irq        = pciIntEn & (dmaIrqStat | st.pgFlag);
  end
endmodule

// File: rtl/sgdma_cmd_chk.sv
module sgdma_cmd_chk
  import sgdma_cmd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdWr,
  input logic [DATA_W-1:0]  wrData,
  input logic               pciIntEn,
  input logic               irq,
  input logic               dmaIrqStat,
  input ctlState_t          st,
  input dpStrobe_t          strobe,
  input logic [COUNT_W-1:0] nextCount,
  input logic [ADDR_W-1:0]  nextAddr,
  input logic [COUNT_W-1:0] curCount,
  input logic [ADDR_W-1:0]  curAddr
);
  p_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.nextValid |=> ($stable(nextCount) && $stable(nextAddr)));

  p_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.handoff |=> (curCount == $past(nextCount) && curAddr == $past(nextAddr) && st.active));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[B_ABORT]) |=> (!st.nextValid && !st.active && !st.done));

  p_done_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!st.enSg) |-> !dmaIrqStat);

  p_pg_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!st.enPg) |=> !st.pgFlag);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> pciIntEn);
endmodule

bind sgdma_cmd_reg sgdma_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .wrData(wrData), .pciIntEn(pciIntEn),
  .irq(irq), .dmaIrqStat(dmaIrqStat), .st(st), .strobe(strobe),
  .nextCount(nextCount), .nextAddr(nextAddr), .curCount(curCount), .curAddr(curAddr)
);

// File: tb/sim_sgdma_cmd_reg.sv
module sim_sgdma_cmd_reg;
  localparam logic [31:0] ENSG = 32'h0800_0000;
  localparam logic [31:0] ENPG = 32'h1000_0000;
  localparam logic [31:0] DIR  = 32'h0200_0000;
  localparam logic [31:0] ST   = 32'h2000_0000;
  localparam logic [31:0] AB   = 32'h0400_0000;
  localparam logic [31:0] DN   = 32'h4000_0000;
  localparam logic [31:0] ALL  = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWr = 1'b0, addrWr = 1'b0, rdSel = 1'b0;
  logic xferDone = 1'b0, pageDone = 1'b0, listPgBit = 1'b0, pciIntEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] curCount;
  logic [31:0] curAddr;
  logic dmaActive, dirRead, burstEn, abortPulse, dmaIrqStat, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int          src;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  sgdma_cmd_reg u0 (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .addrWr(addrWr), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .xferDone(xferDone), .pageDone(pageDone),
    .listPgBit(listPgBit), .pciIntEn(pciIntEn), .curCount(curCount),
    .curAddr(curAddr), .dmaActive(dmaActive), .dirRead(dirRead),
    .burstEn(burstEn), .abortPulse(abortPulse), .dmaIrqStat(dmaIrqStat), .irq(irq)
  );

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      logic [31:0] v;
      item_t it;
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      case (it.src)
        0, 1:    v = rdData;
        2:       v = curAddr;
        3:       v = {16'h0, curCount};
        default: v = {26'h0, dirRead, burstEn, dmaActive, abortPulse, dmaIrqStat, irq};
      endcase
      checks++;
      if ((v & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s src=%0d actual=%h expected=%h", it.tag, it.src,
                 v & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic chk(input int src, input logic [31:0] mask, input logic [31:0] exp,
                     input string tag);
    item_t it;
    rdSel = (src == 1);
    it.src = src; it.mask = mask; it.exp = exp; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    #1;
  endtask

  task automatic wrCmd(input logic [31:0] d, input logic pg);
    @(negedge clk);
    cmdWr = 1'b1; wrData = d; listPgBit = pg;
    @(negedge clk);
    cmdWr = 1'b0; listPgBit = 1'b0;
  endtask

  task automatic wrAdr(input logic [31:0] d);
    @(negedge clk);
    addrWr = 1'b1; wrData = d;
    @(negedge clk);
    addrWr = 1'b0;
  endtask

  task automatic pulseXfer();
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
  endtask

  task automatic pulsePage();
    @(negedge clk); pageDone = 1'b1;
    @(negedge clk); pageDone = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk(0, ALL, 32'h20C0_0000, "R8 reset word");
    chk(4, 32'h3F, 32'h0, "R10 reset outputs");

    // stage a first entry, idle engine
    wrCmd(ENSG | DIR | 32'h123, 1'b0);
    chk(0, 32'hFFFF, 32'h123, "R1 count load");
    chk(0, ALL, 32'h2AC0_0123, "R9 control bits");
    wrAdr(32'hA000_0000);
    chk(1, ALL, 32'hA000_0000, "R1 address load");
    wrCmd(ENSG | DIR | ST | 32'h123, 1'b1);
    chk(0, 32'h2041_0000, 32'h0001_0000, "R2 pending");
    idle(1);
    chk(3, ALL, 32'h123, "R3 count handoff");
    chk(2, ALL, 32'hA000_0000, "R3 address handoff");
    chk(0, ALL, 32'h2A42_0123, "R7 marker moved");

    // queue a second entry behind the active one
    wrCmd(ENSG | DIR | 32'h456, 1'b0);
    wrAdr(32'hB000_0000);
    wrCmd(ENSG | DIR | ST | 32'h456, 1'b0);
    idle(1);
    chk(0, 32'h20C0_0000, 32'h0, "R2 held while active");
    wrCmd(ENSG | DIR | 32'hFFF, 1'b1);
    wrAdr(32'hDEAD_0000);
    chk(0, 32'hFFFF, 32'h456, "R2 count locked");
    chk(1, ALL, 32'hB000_0000, "R1 address locked");

    // page interrupt
    pulsePage();
    chk(0, 32'h0004_0000, 32'h0, "R6 no flag when disabled");
    wrCmd(ENPG | ENSG | DIR, 1'b0);
    pulsePage();
    chk(0, 32'h0004_0000, 32'h0004_0000, "R6 flag set");
    chk(4, 32'h1, 32'h0, "R10 gated by global enable");
    pciIntEn = 1'b1;
    chk(4, 32'h1, 32'h1, "R10 irq from page flag");

    pulseXfer();
    chk(3, ALL, 32'h456, "R3 handoff on done");
    chk(2, ALL, 32'hB000_0000, "R3 address on done");
    chk(0, 32'h60C3_0000, 32'h2040_0000, "R7 marker follows entry");
    chk(0, 32'h0004_0000, 32'h0004_0000, "R6 flag sticky");
    wrCmd(ENSG | DIR, 1'b0);
    idle(1);
    chk(0, 32'h0004_0000, 32'h0, "R6 cleared by enable drop");
    chk(4, 32'h1, 32'h0, "R10 irq low");

    // done flag
    pulseXfer();
    chk(0, DN | 32'h0080_0000, DN | 32'h0080_0000, "R5 done set idle");
    chk(4, 32'h3, 32'h3, "R5 done status and irq");
    wrCmd(DIR, 1'b0);
    chk(4, 32'h3, 32'h0, "R5 done gated by enable");
    chk(0, DN, DN, "R5 done held");
    wrCmd(DN | DIR | ENSG, 1'b0);
    chk(0, DN, 32'h0, "R5 write one clears");
    chk(4, 32'h3, 32'h0, "R10 no source");

    // abort with queued work
    wrCmd(ENSG | ST | 32'h789, 1'b0);
    idle(1);
    wrCmd(ENSG | ST | 32'hAAA, 1'b0);
    chk(0, ST, 32'h0, "R2 second entry queued");
    @(negedge clk);
    cmdWr = 1'b1; wrData = AB | ST | ENSG;
    chk(4, 32'h4, 32'h4, "R4 abort pulse");
    @(negedge clk);
    cmdWr = 1'b0;
    chk(0, 32'h24C0_0000, 32'h20C0_0000, "R4 abort clears");
    idle(2);
    chk(4, 32'h8, 32'h0, "R4 abort beats start");
    chk(0, ST, ST, "R4 nothing staged");

    // reserved bits
    wrCmd(ALL, 1'b0);
    chk(0, 32'h8438_0000, 32'h0, "R11 reserved zero");
    chk(0, 32'h0300_0000, 32'h0300_0000, "R9 readback");
    chk(4, 32'h30, 32'h30, "R9 outputs");
    chk(0, 32'hFFFF, 32'hFFFF, "R1 full count");

    #2;
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule